// File: doc/BRIEF.md
# Pin-Change Interrupt Port

This block watches a group of input pins (eight by default), each brought into the clock domain through a two-flop synchroniser. Each pin has its own programmable edge polarity. When a pin makes its selected transition, a sticky per-pin flag is latched. The flag latches whether or not the pin is enabled. All flags that are both set and enabled merge into one interrupt request line for the whole port.

Software sees three registers over a simple synchronous write bus with a combinational read port. The registers are a per-pin enable mask, a per-pin polarity mask and the flag register. The flag register has two write addresses, one that clears bits and one that sets bits. Hardware never clears a flag; the service routine reads the flags to find the source and writes ones to the clear address for each bit it has handled.

Top module: `pin_edge_irq`

## Requirements
- R1: The enable mask sits at address 0, resets to all zeros, and a write there replaces it; a read at address 0 returns it.
- R2: The polarity mask sits at address 1 and resets to all zeros. Bit value 0 selects a low-to-high transition on that pin, and 1 selects a high-to-low transition. A read at address 1 returns it.
- R3: A pin change driven between two rising clock edges appears in the flag register after the third following rising edge: two synchroniser stages, then the flag register.
- R4: A pin's flag is set by its selected transition whether or not that pin's enable bit is set; the opposite transition does not set it.
- R5: Once set, a flag stays set, whatever the pins do, until software clears it.
- R6: Writing to address 2 clears every flag whose data bit is 1, and leaves flags whose data bit is 0 untouched.
- R7: Writing to address 3 sets every flag whose data bit is 1.
- R8: If a selected transition is detected in the same cycle as a clear write to that flag, the flag stays set.
- R9: Changing a pin's polarity bit while the pin is steady does not set that pin's flag.
- R10: The request output is high exactly when at least one flag is set on a pin whose enable bit is also set. It is a combinational AND-OR of registers.
- R11: Reads at address 2 and at address 3 both return the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 8 | Asynchronous pin inputs |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address for both write and read |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the register at bus_addr_i |
| irq_o | output | 1 | Port interrupt request |

## Verification
The assertions assume that the bus strobe, address and data are synchronous to the clock and settle well before each rising edge. They also assume that reset is asserted before any activity, so the first sampled history is the reset value. The bench changes every input on the falling edge. It holds the pins low through reset and the internal reset-release delay, so the synchroniser never sees a transition that reset would hide. The directed cases place the clear write in the exact cycle where a transition reaches the flag. A random phase mixes pin toggles with writes to all four addresses, so that the same-cycle collisions also occur unplanned.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ENABLE   = 2'd0,
    SEL_POLARITY = 2'd1,
    SEL_FLAG_CLR = 2'd2,
    SEL_FLAG_SET = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q, stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = async_i;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/pei_edge.sv
module pei_edge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] det_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise, fall;

  always_comb begin
    rise  = cur_i & ~prev_q;
    fall  = ~cur_i & prev_q;
    det_o = (rise & ~pol_i) | (fall & pol_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  // R9
  steady_no_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((~(cur_i ^ prev_q) & det_o) == '0));
endmodule

// File: rtl/pei_regs.sv
module pei_regs
  import pei_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  det_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  flag_o
);
  logic [WIDTH-1:0] en_q, pol_q, flag_q;
  logic [WIDTH-1:0] en_d, pol_d, flag_d;
  logic [WIDTH-1:0] clr_w, set_w;
  logic             en_ce, pol_ce;
  reg_sel_e         sel;

  always_comb begin
    sel    = reg_sel_e'(addr_i);
    en_ce  = we_i && (sel == SEL_ENABLE);
    pol_ce = we_i && (sel == SEL_POLARITY);
    clr_w  = (we_i && (sel == SEL_FLAG_CLR)) ? wdata_i : '0;
    set_w  = (we_i && (sel == SEL_FLAG_SET)) ? wdata_i : '0;
    en_d   = wdata_i;
    pol_d  = wdata_i;
    flag_d = (flag_q & ~clr_w) | set_w | det_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      flag_q <= '0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (pol_ce) pol_q <= pol_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ENABLE:   rdata_o = en_q;
      SEL_POLARITY: rdata_o = pol_q;
      default:      rdata_o = flag_q;
    endcase
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign flag_o = flag_q;

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q) & ~$past(clr_w) & ~flag_q) == '0));
  // R8
  clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_i & clr_w) != '0) |=> (($past(det_i & clr_w) & ~flag_q) == '0));
  // R6
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_w & ~det_i & ~set_w) != '0) |=> (($past(clr_w & ~det_i & ~set_w) & flag_q) == '0));
  // R7
  set_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> (($past(set_w) & ~flag_q) == '0));
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pei_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [RST_STAGES-1:0] rst_q, rst_d;
  logic                  rst_n;
  logic [NPINS-1:0]      pin_sync, det, en, pol, flag;

  generate
    if (RST_STAGES == 1) begin : g_rst1
      always_comb rst_d = 1'b1;
    end else begin : g_rstn
      always_comb rst_d = {rst_q[RST_STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= rst_d;
  end

  assign rst_n = rst_q[RST_STAGES-1];

  pei_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  pei_edge #(.WIDTH(NPINS)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i (pin_sync),
    .pol_i (pol),
    .det_o (det)
  );

  pei_regs #(.WIDTH(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .det_i   (det),
    .rdata_o (bus_rdata_o),
    .en_o    (en),
    .pol_o   (pol),
    .flag_o  (flag)
  );

  assign irq_o = |(flag & en);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_o);
  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag != '0));
endmodule

// File: tb/sim_pin_edge_irq.sv
`timescale 1ns/100ps
module sim_pin_edge_irq;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] pins;
  logic         we;
  logic [1:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pin_edge_irq u0 (
    .clk         (clk),
    .rst_ni      (rst_n),
    .pin_i       (pins),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // behavioural reference
  logic [W-1:0] m_en, m_pol, m_flag;
  logic [W-1:0] hist[$];

  always @(posedge clk) begin
    logic [W-1:0] older, newer, hit, clr, setm;
    if (!rst_n) begin
      m_en = '0; m_pol = '0; m_flag = '0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      older = hist[2];
      newer = hist[1];
      hit   = '0;
      for (int b = 0; b < W; b++) begin
        if (m_pol[b] == 1'b0 && !older[b] && newer[b]) hit[b] = 1'b1;
        if (m_pol[b] == 1'b1 && older[b] && !newer[b]) hit[b] = 1'b1;
      end
      clr  = (we && addr == 2'd2) ? wdata : '0;
      setm = (we && addr == 2'd3) ? wdata : '0;
      m_flag = (m_flag & ~clr) | setm | hit;
      if (we && addr == 2'd0) m_en  = wdata;
      if (we && addr == 2'd1) m_pol = wdata;
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic logic [W-1:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_en;
      2'd1:    return m_pol;
      default: return m_flag;
    endcase
  endfunction

  // cycle-by-cycle comparison
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      n_chk++;
      if (rdata !== model_read(addr)) begin
        n_bad++;
        $display("FAIL R%0s read addr %0d: actual %h expected %h",
                 addr == 0 ? "1" : addr == 1 ? "2" : "11", addr, rdata, model_read(addr));
      end
      n_chk++;
      if (irq !== ((m_flag & m_en) != '0)) begin
        n_bad++;
        $display("FAIL R10 irq: actual %b expected %b", irq, (m_flag & m_en) != '0);
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk); we = 1'b0; addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic drive(input logic [W-1:0] p);
    @(negedge clk); we = 1'b0; pins = p;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); we = 1'b0; end
  endtask

  initial begin
    rst_n = 1'b0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // reset state
    rd(2'd0, 8'h00, "R1 enable reset");
    rd(2'd1, 8'h00, "R2 polarity reset");
    rd(2'd2, 8'h00, "R11 flags reset");
    chk("R10 irq reset", {7'd0, irq}, 8'h00);

    // R3 latency, R4 flag with enable off
    drive(8'h01);
    rd(2'd2, 8'h00, "R3 after one edge");
    rd(2'd2, 8'h00, "R3 after two edges");
    rd(2'd2, 8'h01, "R3 after three edges");
    chk("R4 masked pin no irq", {7'd0, irq}, 8'h00);

    // R6 clear
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h00, "R6 clear");

    // R7 set, R10 irq, R11 alias
    wr(2'd3, 8'h80);
    rd(2'd3, 8'h80, "R11 read via set address");
    wr(2'd0, 8'h80);
    rd(2'd0, 8'h80, "R1 enable write");
    chk("R10 irq on enabled flag", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h7F);
    rd(2'd2, 8'h80, "R6 zero bits untouched");
    wr(2'd2, 8'h80);
    rd(2'd2, 8'h00, "R7 clear after set");

    // R2 falling polarity on pin1
    wr(2'd1, 8'h02);
    rd(2'd1, 8'h02, "R2 polarity write");
    drive(8'h03);
    idle(4);
    rd(2'd2, 8'h00, "R4 opposite edge ignored");
    drive(8'h01);
    idle(4);
    rd(2'd2, 8'h02, "R2 falling edge flagged");

    // R5 hold across pin activity
    drive(8'h03);
    idle(2);
    drive(8'h01);
    idle(6);
    rd(2'd2, 8'h02, "R5 flag holds");
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h00, "R6 clear all");

    // R9 polarity change on steady-high pin2
    drive(8'h05);
    idle(4);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h04);
    idle(4);
    wr(2'd1, 8'h00);
    idle(4);
    rd(2'd2, 8'h00, "R9 polarity change no flag");

    // R8 clear in same cycle as detection on pin3
    drive(8'h0D);
    idle(1);
    wr(2'd2, 8'h08);
    rd(2'd2, 8'h08, "R8 edge wins over clear");
    wr(2'd0, 8'h08);
    rd(2'd0, 8'h08, "R1 enable pin3");
    chk("R10 irq pin3", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h08);
    rd(2'd2, 8'h00, "R6 clear pin3");
    chk("R10 irq dropped", {7'd0, irq}, 8'h00);

    // random phase
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      we    = ($urandom % 4) == 0;
      addr  = 2'($urandom);
      wdata = W'($urandom);
      if (($urandom % 3) == 0) pins = pins ^ W'($urandom);
    end
    idle(6);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog R3: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule